// File: doc/BRIEF.md
# Dual-Select Byte-Lane Static RAM Model

This block is a synthesizable, clock-based model of an asynchronous static RAM word array with 16-bit words split into two byte lanes. The bidirectional data bus of a real device is modelled as a write-data input, a read-data output and one drive-enable bit per byte lane. Two chip selects of opposite polarity must both be asserted before anything happens. An output enable and a write enable choose between reading, writing and keeping the outputs quiet. A per-lane enable, active low, picks which bytes take part.

Reads are combinational from the current address, as on the asynchronous part. Writes commit on the rising clock edge while the write condition holds. The full-size address port is kept at 19 bits, but only the low `ROWS_LOG2` bits select a word, so the array stays small enough to build from registers. A standby flag reports when the part is deselected or has no lane enabled.

All pins here are plain control and data signals. There is no valid/ready stream: each cycle's pin levels fully define the access, and the block never applies back-pressure.

Top module: `byte_lane_sram`

## Requirements
- R1: The part is selected only when `sel_n` is 0 and `sel_hi` is 1. Otherwise `lane_drive` is 2'b00, `rdata` is zero, `standby` is 1 and no word changes.
- R2: When the part is selected and both `lane_en_n` bits are 1, `standby` is 1, `lane_drive` is 2'b00 and no word changes, whatever `we_n` and `oe_n` are.
- R3: When the part is selected with at least one lane enabled, `we_n` = 1 and `oe_n` = 1, `lane_drive` is 2'b00 and no word changes.
- R4: When the part is selected with at least one lane enabled, `we_n` = 1 and `oe_n` = 0, `lane_drive[i]` equals `~lane_en_n[i]` and each driven lane shows the stored byte of the word at the current address in the same cycle. Lane 0 is `rdata[7:0]` and lane 1 is `rdata[15:8]`.
- R5: Every `rdata` lane whose `lane_drive` bit is 0 reads as zero.
- R6: When the part is selected with `we_n` = 0, each lane whose `lane_en_n` bit is 0 takes its byte from `wdata` at the next rising clock edge, whatever `oe_n` is. Lanes that are not enabled keep their old byte, and `lane_drive` stays 2'b00.
- R7: Only `addr[ROWS_LOG2-1:0]` selects the word. Addresses that differ only in higher bits reach the same word.
- R8: While `rst_n` is 0 every word is cleared to zero. `standby` is 1 exactly when the part is deselected or both lanes are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write commit clock |
| rst_n | input | 1 | Active-low reset, clears the array |
| addr | input | ADDR_W (19) | Word address; only the low ROWS_LOG2 bits are used |
| sel_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; takes priority over oe_n |
| lane_en_n | input | LANES (2) | Byte-lane enables, active low; bit 0 lower byte, bit 1 upper byte |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Read data; zero on lanes that are not driven |
| lane_drive | output | LANES (2) | Per-lane output drive enable |
| standby | output | 1 | 1 when deselected or no lane is enabled |

## Verification
The bench goes after the mode priorities. A write with output enable low must neither drive the bus nor be lost; a faulty priority would drive stale data or drop the write. Selected cycles with both lanes off, and each select polarity on its own, must leave memory untouched and raise standby; a decoder that checks only one select, or ignores the lane pair, would corrupt words. Single-lane reads and writes must leave the other lane zero on the bus and unchanged in the array, which catches swapped lane indices. Accesses whose addresses differ only above the used bits must alias, which exposes any decoding of the upper bits.

// File: rtl/sram_mode_pkg.sv
`timescale 1ns/1ps
package sram_mode_pkg;

  typedef enum logic [2:0] {
    MODE_DESEL  = 3'd0,
    MODE_NOLANE = 3'd1,
    MODE_OUTOFF = 3'd2,
    MODE_READ   = 3'd3,
    MODE_WRITE  = 3'd4
  } sram_mode_e;

endpackage

// File: rtl/sram_mode_decode.sv
`timescale 1ns/1ps
module sram_mode_decode
  import sram_mode_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_n,
  input  logic             sel_hi,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic [LANES-1:0] lane_en_n,
  output sram_mode_e       mode,
  output logic [LANES-1:0] lane_wr,
  output logic [LANES-1:0] lane_rd
);

  logic selected;
  logic any_lane;

  assign selected = ~sel_n & sel_hi;
  assign any_lane = ~(&lane_en_n);

  // Priority: select, lane presence, write, read, otherwise quiet.
  always_comb begin
    if (!selected)      mode = MODE_DESEL;
    else if (!any_lane) mode = MODE_NOLANE;
    else if (!we_n)     mode = MODE_WRITE;
    else if (!oe_n)     mode = MODE_READ;
    else                mode = MODE_OUTOFF;
  end

  always_comb begin
    lane_wr = '0;
    lane_rd = '0;
    if (mode == MODE_WRITE) lane_wr = ~lane_en_n;
    if (mode == MODE_READ)  lane_rd = ~lane_en_n;
  end

endmodule

// File: rtl/sram_lane_bank.sv
`timescale 1ns/1ps
module sram_lane_bank #(
  parameter int ROWS_LOG2 = 8,
  parameter int LANE_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ROWS_LOG2-1:0] row,
  input  logic [LANE_W-1:0]    din,
  output logic [LANE_W-1:0]    dout
);

  localparam int ROWS = 1 << ROWS_LOG2;

  logic [LANE_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (wr_en) begin
      mem_q[row] <= din;
    end
  end

  assign dout = mem_q[row];

  // R6
  lane_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_q[$past(row)] == $past(din)));

  // R3
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (mem_q[$past(row)] == $past(dout)));

endmodule

// File: rtl/byte_lane_sram.sv
`timescale 1ns/1ps
module byte_lane_sram
  import sram_mode_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int ROWS_LOG2 = 8,
  parameter int DATA_W    = 16,
  parameter int LANE_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          sel_n,
  input  logic                          sel_hi,
  input  logic                          oe_n,
  input  logic                          we_n,
  input  logic [DATA_W/LANE_W-1:0]      lane_en_n,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [DATA_W/LANE_W-1:0]      lane_drive,
  output logic                          standby
);

  localparam int LANES = DATA_W / LANE_W;

  sram_mode_e              mode;
  logic [LANES-1:0]        lane_wr;
  logic [LANES-1:0]        lane_rd;
  logic [ROWS_LOG2-1:0]    row;
  logic                    addr_hi_unused;

  assign row = addr[ROWS_LOG2-1:0];

  generate
    if (ADDR_W > ROWS_LOG2) begin : g_hi
      assign addr_hi_unused = ^addr[ADDR_W-1:ROWS_LOG2];
    end else begin : g_nohi
      assign addr_hi_unused = 1'b0;
    end
  endgenerate

  sram_mode_decode #(.LANES(LANES)) u_decode (
    .sel_n     (sel_n),
    .sel_hi    (sel_hi),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .lane_en_n (lane_en_n),
    .mode      (mode),
    .lane_wr   (lane_wr),
    .lane_rd   (lane_rd)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] stored;

      sram_lane_bank #(.ROWS_LOG2(ROWS_LOG2), .LANE_W(LANE_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (lane_wr[i]),
        .row   (row),
        .din   (wdata[i*LANE_W +: LANE_W]),
        .dout  (stored)
      );

      assign rdata[i*LANE_W +: LANE_W] = lane_rd[i] ? stored : '0;
      assign lane_drive[i]             = lane_rd[i];

      // R5
      idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_drive[i] |-> (rdata[i*LANE_W +: LANE_W] == '0));
    end
  endgenerate

  assign standby = (mode == MODE_DESEL) || (mode == MODE_NOLANE);

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !sel_hi) |-> (standby && (lane_drive == '0)));

  // R6
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel_hi && !we_n) |-> (lane_drive == '0));

  // R2
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> ((lane_drive == '0) && (lane_wr == '0)));

  // R4
  read_lane_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel_hi && we_n && !oe_n) |-> (lane_drive == LANES'(~lane_en_n)));

endmodule

// File: tb/byte_lane_sram_test.sv
`timescale 1ns/1ps
module byte_lane_sram_test;

  localparam int ADDR_W    = 19;
  localparam int ROWS_LOG2 = 8;
  localparam int ROWS      = 1 << ROWS_LOG2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              sel_n = 1'b1;
  logic              sel_hi = 1'b0;
  logic              oe_n = 1'b1;
  logic              we_n = 1'b1;
  logic [1:0]        lane_en_n = 2'b11;
  logic [15:0]       wdata = '0;
  logic [15:0]       rdata;
  logic [1:0]        lane_drive;
  logic              standby;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;

  logic [15:0] model [ROWS];

  always #5 clk = ~clk;

  byte_lane_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel_hi(sel_hi),
    .oe_n(oe_n), .we_n(we_n), .lane_en_n(lane_en_n), .wdata(wdata),
    .rdata(rdata), .lane_drive(lane_drive), .standby(standby)
  );

  function automatic bit f_sel(logic sn, logic sh);
    return !sn && sh;
  endfunction

  function automatic bit f_any(logic [1:0] len);
    return len != 2'b11;
  endfunction

  function automatic logic [1:0] f_drive(logic sn, logic sh, logic oe, logic we, logic [1:0] len);
    if (f_sel(sn, sh) && f_any(len) && we && !oe) return ~len;
    return 2'b00;
  endfunction

  function automatic logic [15:0] f_rdata(logic [1:0] drv, logic [15:0] word);
    logic [15:0] r;
    r[7:0]  = drv[0] ? word[7:0]  : 8'h00;
    r[15:8] = drv[1] ? word[15:8] : 8'h00;
    return r;
  endfunction

  task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // One access: drive at the falling edge, check combinational outputs,
  // then let the rising edge commit and update the model.
  task automatic step(logic sn, logic sh, logic oe, logic we, logic [1:0] len,
                      logic [ADDR_W-1:0] a, logic [15:0] wd);
    string tag;
    logic [1:0]  edrv;
    logic [ROWS_LOG2-1:0] row;
    bit sel;
    bit any;
    @(negedge clk);
    sel_n = sn; sel_hi = sh; oe_n = oe; we_n = we; lane_en_n = len;
    addr = a; wdata = wd;
    #2;
    row  = a[ROWS_LOG2-1:0];
    sel  = f_sel(sn, sh);
    any  = f_any(len);
    edrv = f_drive(sn, sh, oe, we, len);
    if (!sel)                 tag = "R1";
    else if (!any)            tag = "R2";
    else if (!we)             tag = "R6";
    else if (oe)              tag = "R3";
    else if (len != 2'b00)    tag = "R5";
    else                      tag = "R4";
    check(tag, "lane_drive", {14'd0, lane_drive}, {14'd0, edrv});
    check(tag, "rdata", rdata, f_rdata(edrv, model[row]));
    check("R8", "standby", {15'd0, standby}, {15'd0, (!sel || !any)});
    @(posedge clk);
    if (sel && any && !we) begin
      if (!len[0]) model[row][7:0]  = wd[7:0];
      if (!len[1]) model[row][15:8] = wd[15:8];
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    for (int r = 0; r < ROWS; r++) model[r] = 16'h0000;
    void'($urandom(32'h5EED_1234));

    // R8: reset clears, standby while deselected in reset
    repeat (3) @(posedge clk);
    #2;
    check("R8", "standby in reset", {15'd0, standby}, 16'd1);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 19'h00000, 16'h0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 19'h000FF, 16'h0);

    // R6: word write with output enable high, then read back (R4)
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 19'h00005, 16'hA1B2);
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 19'h00005, 16'h0);
    // R6: lower-byte write while output enable is low
    step(1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 19'h00005, 16'h7733);
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 19'h00005, 16'h0);
    // R5: upper-only and lower-only reads
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 19'h00005, 16'h0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 19'h00005, 16'h0);
    // R3: output disabled, write data present, no change
    step(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 19'h00005, 16'hFFFF);
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 19'h00005, 16'h0);
    // R2: both lanes off with write enable low
    step(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 19'h00005, 16'hDEAD);
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 19'h00005, 16'h0);
    // R1: each select inactive on its own, write attempted
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 19'h00005, 16'hBEEF);
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 19'h00005, 16'hCAFE);
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 19'h00005, 16'h0);
    // R7: aliasing through unused upper address bits
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 19'h10023, 16'h5A5A);
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 19'h00023, 16'h0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 19'h7FF23, 16'h0);
    check("R7", "alias word", rdata, 16'h5A5A);

    // Random mix, biased toward selected cycles
    for (int k = 0; k < 3000; k++) begin
      logic sn, sh;
      sn = ($urandom_range(0, 9) == 0);
      sh = ($urandom_range(0, 9) != 0);
      step(sn, sh, 1'($urandom), 1'($urandom), 2'($urandom),
           19'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule